// File: doc/BRIEF.md
# Segment Table Address Translator

The block maps a 14-bit virtual address onto a physical address through a table of four segments. The top two address bits pick a segment. The low twelve bits form an offset into that segment. Each table entry holds a physical start address, a segment length and a two-bit access right. A request is accepted over a valid/ready handshake. One cycle later the response carries either the translated address or a fault with its cause.

Translation is refused in two cases. A bounds fault is raised when the offset is not below the segment length. A protection fault is raised when the access right forbids the request. The kernel rewrites table entries one at a time through a write port, for example to swap in another process's segments on a context switch. A write only affects requests accepted in later cycles.

Top module: `seg_xlate`

## Requirements
- R1: For an allowed, in-range request, rsp_paddr equals the entry's base plus the 12-bit offset (vaddr[11:0]), truncated to PA_BITS. The response has rsp_fault=0 and rsp_cause=0.
- R2: When the offset is greater than or equal to the entry's length, the response has rsp_fault=1, rsp_cause=1 (bounds) and rsp_paddr=0.
- R3: Rights are encoded as 0 = no access, 1 = read only, 2 or 3 = read and write. A write to a read-only entry, or any request to a no-access entry, gives rsp_fault=1, rsp_cause=2 (protection) and rsp_paddr=0. Protection takes priority over bounds.
- R4: After reset the table is loaded as follows:
  - entry 0: base 0x4000, length 0x700, read only
  - entry 1: base 0x0, length 0x500, read/write
  - entry 2: base 0x0, length 0, no access
  - entry 3: base 0x2000, length 0x1000, read/write

  With this table, a read of 0x0240 yields 0x4240 and a read of 0x1108 yields 0x0108.
- R5: A request accepted at a clock edge (req_valid and req_ready both high) makes rsp_valid high after that edge. rsp_valid falls after an edge where the response is taken and no new request is accepted.
- R6: While rsp_valid is high and rsp_ready is low, req_ready is low, and rsp_paddr, rsp_fault and rsp_cause hold their values.
- R7: A table write (tw_en high, slot tw_idx) that shares an edge with an accepted request does not affect that request's response. It does affect every request accepted afterwards.
- R8: While rst is high and in the cycle after it, rsp_valid is low. req_ready is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request can be accepted |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_vaddr | input | 14 | segment number [13:12], offset [11:0] |
| rsp_valid | output | 1 | response present |
| rsp_ready | input | 1 | response taken |
| rsp_paddr | output | 16 | physical address, 0 on fault |
| rsp_fault | output | 1 | translation refused |
| rsp_cause | output | 2 | 0 none, 1 bounds, 2 protection |
| tw_en | input | 1 | table entry write strobe |
| tw_idx | input | 2 | entry being written |
| tw_base | input | 16 | new physical start |
| tw_size | input | 13 | new segment length |
| tw_prot | input | 2 | new access right |

## Verification
The bound assertions check the handshake rules on every cycle:
- an accepted request yields a response on the next cycle;
- a stalled response holds steady and keeps req_ready low;
- a faulted response carries a zero address;
- a fault flag always comes with a non-zero cause.

Only the bench scenarios can show that the right address or cause comes out. These cover the arithmetic, the bounds edge at length minus one, the access-right decoding, and the priority of protection over bounds. They also cover the reset table contents and the timing of a table write against a lookup in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam logic [1:0] RIGHT_NONE = 2'd0;
  localparam logic [1:0] RIGHT_RO   = 2'd1;
  localparam logic [1:0] RIGHT_RW   = 2'd2;

  localparam logic [1:0] CAUSE_OK     = 2'd0;
  localparam logic [1:0] CAUSE_BOUNDS = 2'd1;
  localparam logic [1:0] CAUSE_PROT   = 2'd2;

  // power-up contents of the table, per entry
  function automatic logic [31:0] init_base(input int idx);
    case (idx)
      0:       return 32'h4000;
      3:       return 32'h2000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] init_size(input int idx);
    case (idx)
      0:       return 32'h700;
      1:       return 32'h500;
      3:       return 32'h1000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [1:0] init_right(input int idx);
    case (idx)
      0:       return RIGHT_RO;
      2:       return RIGHT_NONE;
      default: return RIGHT_RW;
    endcase
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int IDX_BITS = 2,
  parameter int PA_BITS  = 16,
  parameter int SZ_BITS  = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [PA_BITS-1:0]  wr_base,
  input  logic [SZ_BITS-1:0]  wr_size,
  input  logic [1:0]          wr_right,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic [PA_BITS-1:0]  rd_base,
  output logic [SZ_BITS-1:0]  rd_size,
  output logic [1:0]          rd_right
);
  localparam int NUM_SEG = 1 << IDX_BITS;

  logic [PA_BITS-1:0] base_q  [NUM_SEG];
  logic [SZ_BITS-1:0] size_q  [NUM_SEG];
  logic [1:0]         right_q [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_entry
    localparam logic [31:0] BASE0 = init_base(i);
    localparam logic [31:0] SIZE0 = init_size(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i]  <= BASE0[PA_BITS-1:0];
        size_q[i]  <= SIZE0[SZ_BITS-1:0];
        right_q[i] <= init_right(i);
      end else if (wr_en && wr_idx == IDX_BITS'(i)) begin
        base_q[i]  <= wr_base;
        size_q[i]  <= wr_size;
        right_q[i] <= wr_right;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_size  = size_q[rd_idx];
  assign rd_right = right_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  parameter int SZ_BITS  = 13
) (
  input  logic [OFF_BITS-1:0] offset,
  input  logic                is_write,
  input  logic [PA_BITS-1:0]  base,
  input  logic [SZ_BITS-1:0]  size,
  input  logic [1:0]          right,
  output logic [1:0]          cause,
  output logic [PA_BITS-1:0]  paddr
);
  logic denied, outside;

  always_comb begin
    denied  = (right == RIGHT_NONE) || (right == RIGHT_RO && is_write);
    outside = SZ_BITS'(offset) >= size;
    if (denied)       cause = CAUSE_PROT;
    else if (outside) cause = CAUSE_BOUNDS;
    else              cause = CAUSE_OK;
    paddr = (cause == CAUSE_OK) ? base + PA_BITS'(offset) : '0;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int IDX_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  parameter int SZ_BITS  = OFF_BITS + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [IDX_BITS+OFF_BITS-1:0] req_vaddr,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [PA_BITS-1:0]           rsp_paddr,
  output logic                         rsp_fault,
  output logic [1:0]                   rsp_cause,
  input  logic                         tw_en,
  input  logic [IDX_BITS-1:0]          tw_idx,
  input  logic [PA_BITS-1:0]           tw_base,
  input  logic [SZ_BITS-1:0]           tw_size,
  input  logic [1:0]                   tw_prot
);
  localparam int VA_BITS = IDX_BITS + OFF_BITS;

  logic [IDX_BITS-1:0] seg_sel;
  logic [OFF_BITS-1:0] seg_off;
  logic [PA_BITS-1:0]  ent_base, xl_paddr;
  logic [SZ_BITS-1:0]  ent_size;
  logic [1:0]          ent_right, xl_cause;
  logic                take;

  assign seg_sel = req_vaddr[VA_BITS-1:OFF_BITS];
  assign seg_off = req_vaddr[OFF_BITS-1:0];

  seg_table #(.IDX_BITS(IDX_BITS), .PA_BITS(PA_BITS), .SZ_BITS(SZ_BITS)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_base(tw_base), .wr_size(tw_size), .wr_right(tw_prot),
    .rd_idx(seg_sel), .rd_base(ent_base), .rd_size(ent_size), .rd_right(ent_right)
  );

  seg_check #(.OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS), .SZ_BITS(SZ_BITS)) u_check (
    .offset(seg_off), .is_write(req_write),
    .base(ent_base), .size(ent_size), .right(ent_right),
    .cause(xl_cause), .paddr(xl_paddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_OK;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= xl_paddr;
        rsp_fault <= (xl_cause != CAUSE_OK);
        rsp_cause <= xl_cause;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_BITS = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_BITS-1:0] rsp_paddr,
  input logic               rsp_fault,
  input logic [1:0]         rsp_cause
);
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_drain_r5: assert property (@(posedge clk) disable iff (rst)
    (!(req_valid && req_ready) && rsp_valid && rsp_ready) |=> !rsp_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause) && $stable(rsp_fault)));

  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_fault_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  p_cause_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

  p_reset_r8: assert property (@(posedge clk) rst |=> !rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_BITS(PA_BITS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [13:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic        tw_en = 1'b0;
  logic [1:0]  tw_idx = '0, tw_prot = '0;
  logic [15:0] tw_base = '0;
  logic [12:0] tw_size = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [13:0] va;
    logic [1:0]  cause;
    logic [15:0] pa;
  } vec_t;

  // reset table: e0 0x4000/0x700 RO, e1 0x0/0x500 RW, e2 0/0 none, e3 0x2000/0x1000 RW
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 14'h0240, 2'd0, 16'h4240},  // R4
    '{1'b0, 14'h1108, 2'd0, 16'h0108},  // R4
    '{1'b0, 14'h06FF, 2'd0, 16'h46FF},  // R1 last byte
    '{1'b0, 14'h0700, 2'd1, 16'h0000},  // R2 first byte past end
    '{1'b1, 14'h0010, 2'd2, 16'h0000},  // R3 write to read-only
    '{1'b0, 14'h2000, 2'd2, 16'h0000},  // R3 no access beats bounds
    '{1'b1, 14'h3FFF, 2'd0, 16'h2FFF},  // R1
    '{1'b1, 14'h14FF, 2'd0, 16'h04FF},  // R1
    '{1'b0, 14'h1500, 2'd1, 16'h0000},  // R2
    '{1'b1, 14'h0700, 2'd2, 16'h0000}   // R3 priority over bounds
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic [13:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [1:0] cause, input logic [15:0] pa);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " cause"}, 32'(rsp_cause), 32'(cause));
    check({req, " fault"}, 32'(rsp_fault), 32'(cause != 2'd0));
    check({req, " paddr"}, 32'(rsp_paddr), 32'(pa));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 valid after reset", 32'(rsp_valid), 32'd0);
    check("R8 ready after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].wr, VECS[i].va);
      expect_rsp($sformatf("R1-vec%0d", i), VECS[i].cause, VECS[i].pa);
    end

    // R5: idle cycle drops valid
    @(negedge clk);
    check("R5 valid drops", 32'(rsp_valid), 32'd0);

    // R6: backpressure
    rsp_ready = 1'b0;
    send(1'b0, 14'h0240);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 14'h1108;
    check("R6 ready low", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    expect_rsp("R6 held", 2'd0, 16'h4240);
    check("R6 ready still low", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R6 second", 2'd0, 16'h0108);

    // R7: table write in the same cycle as a lookup
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 14'h1108;
    tw_en = 1'b1; tw_idx = 2'd1; tw_base = 16'h8000; tw_size = 13'h100; tw_prot = 2'd2;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; tw_en = 1'b0;
    expect_rsp("R7 old entry used", 2'd0, 16'h0108);
    send(1'b0, 14'h1108);
    expect_rsp("R7 new length", 2'd1, 16'h0000);
    send(1'b1, 14'h10FF);
    expect_rsp("R7 new base", 2'd0, 16'h80FF);

    // R3: code 3 acts as read/write; code 0 blocks reads
    @(negedge clk);
    tw_en = 1'b1; tw_idx = 2'd0; tw_base = 16'h1000; tw_size = 13'h10; tw_prot = 2'd3;
    @(negedge clk);
    tw_en = 1'b0;
    send(1'b1, 14'h0005);
    expect_rsp("R3 code3 write", 2'd0, 16'h1005);
    @(negedge clk);
    tw_en = 1'b1; tw_prot = 2'd0;
    @(negedge clk);
    tw_en = 1'b0;
    send(1'b0, 14'h0005);
    expect_rsp("R3 none read", 2'd2, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule